// File: doc/BRIEF.md
# Reference Frequency Qualifier

This block watches six reference clocks, each arriving as a one-cycle edge strobe that has already been synchronized to the local clock. A shared gate timer opens measurement windows of a fixed number of local cycles. In each window the block counts the edges of every reference. At the end of the window it compares each count with the count expected for a perfect reference. It turns the difference into a signed fractional offset in half-ppm steps and saturates that offset to a byte. It then assigns each reference one of four status codes. The inputs behind the status are presence (a missing-edge timeout), a 4-bit priority whose zero value takes the reference out of service, and a programmable acceptance window.

After the statuses are refreshed, a selector picks one reference among those that qualify. By default it picks the one with the highest priority. When both automatic switching and best-offset selection are requested, it picks the one with the smallest absolute offset instead. A flag reports whether any reference qualified at all. Higher-level switching logic uses the offsets, statuses and selection to decide where to lock.

Top module: `ref_qual_top`

## Requirements
- R1: At the end of each window of GATE_CYC local cycles, the count of edges seen in that window (a strobe in the last cycle included) gives the offset (count − expected)·HPPM / expected. The division truncates toward zero, and an expected count of zero is treated as one. The offset is published as an 8-bit two's-complement byte in half-ppm units, one cycle after the last cycle of the window. Reference i uses bits [8i+7:8i] of the offset bus.
- R2: An offset above +126 is published as 0x7E (+63 ppm), and an offset below −126 is published as 0x82 (−63 ppm).
- R3: A reference whose strobe was low in the last cycle of the window and in each of the MISS_CYC cycles before it reports status 00 (absent).
- R4: A present reference with a nonzero priority reports status 01 when the magnitude of its published offset exceeds the window byte (unsigned, 0.5 ppm per step). Otherwise it reports status 11 (qualified). Reference i uses bits [2i+1:2i] of the status bus.
- R5: A present reference whose priority nibble is 0000 reports status 10 whatever its offset, and it is never selected.
- R6: During and right after reset, every offset byte is 0xFF, every status is 00, the any-qualified flag is 0 and the selected index is 0.
- R7: In priority mode, the selected index is the qualified reference with the largest priority nibble (1111 highest, 0001 lowest). Reference i takes priority bits [4i+3:4i]. A tie goes to the lower index.
- R8: When the automatic-switching input and the best-offset input are both 1, the selected index is the qualified reference with the smallest absolute offset, and a tie goes to the lower index. With either input at 0, priority mode applies.
- R9: The any-qualified flag and the selected index are updated one cycle after the statuses. When no reference qualifies, the flag is 0 and the index is 0.
- R10: Offsets, statuses, the flag and the index hold their values between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | NREF | One-cycle edge strobe per reference |
| exp_cnt | input | NREF*CNT_W | Expected edge count per window, per reference |
| acc_win | input | 8 | Acceptance window, 0.5 ppm per step |
| prio_cfg | input | 4*NREF | Priority nibble per reference |
| auto_sw | input | 1 | Automatic switching enabled |
| min_off_sel | input | 1 | Best-offset selection requested |
| ofs_out | output | 8*NREF | Signed half-ppm offset per reference |
| stat_out | output | 2*NREF | Status code per reference |
| any_ok | output | 1 | At least one reference qualified |
| sel_idx | output | $clog2(NREF) | Index of the selected reference |

## Verification
The bench builds the block with a 200-cycle window, a 20-cycle missing-edge timeout and a scale numerator of 200 in place of two million. With these values, a difference of a single edge against an expected count near fifty lands a few half-ppm steps away from zero. That makes truncation, the window boundary and both saturation limits reachable in a few hundred cycles. Expected counts are chosen so that positive and negative truncation, status 01 and both priority and offset ties each occur within one window.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

    typedef enum logic [1:0] {
        ST_ABSENT = 2'b00,
        ST_OFFWIN = 2'b01,
        ST_IDLE   = 2'b10,
        ST_GOOD   = 2'b11
    } ref_st_e;

    localparam int OFS_LIM = 126;

    function automatic logic [7:0] mag8(input logic [7:0] v);
        return v[7] ? (8'd0 - v) : v;
    endfunction

endpackage

// File: rtl/rfq_gate.sv
module rfq_gate #(
    parameter int GATE_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end,
    output logic upd
);
    localparam int GW = $clog2(GATE_CYC);

    typedef struct packed {
        logic [GW-1:0] cnt;
        logic          upd;
    } gate_t;

    gate_t q, d;

    assign gate_end = (q.cnt == GW'(GATE_CYC - 1));
    assign upd      = q.upd;

    always_comb begin
        d     = q;
        d.upd = gate_end;
        d.cnt = gate_end ? '0 : q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r9_upd_follows_gate: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end |=> upd);

endmodule

// File: rtl/rfq_chan.sv
module rfq_chan
    import rfq_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int MISS_CYC = 1000,
    parameter int HPPM     = 2000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             gate_end,
    input  logic [CNT_W-1:0] exp_cnt,
    input  logic [7:0]       win,
    input  logic [3:0]       prio,
    output logic [7:0]       ofs_o,
    output logic [1:0]       st_o
);
    localparam int MW = $clog2(MISS_CYC + 1);
    localparam logic signed [63:0] HPPM_S = 64'(HPPM);
    localparam logic signed [63:0] LIM_S  = 64'(OFS_LIM);

    typedef struct packed {
        logic [CNT_W-1:0] ecnt;
        logic [MW-1:0]    miss;
        logic [7:0]       ofs;
        logic [1:0]       st;
    } chan_t;

    chan_t q, d;

    logic [CNT_W:0]     sum;
    logic [CNT_W-1:0]   meas;
    logic [CNT_W-1:0]   den;
    logic               present;
    logic signed [63:0] diff_s;
    logic signed [63:0] quo_s;
    logic [7:0]         ofs_n;
    logic [7:0]         ofs_mag;
    ref_st_e            st_n;

    assign ofs_o = q.ofs;
    assign st_o  = q.st;

    always_comb begin
        d       = q;
        sum     = {1'b0, q.ecnt} + {{CNT_W{1'b0}}, edge_i};
        meas    = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        present = edge_i || (q.miss < MW'(MISS_CYC));
        den     = (exp_cnt == '0) ? CNT_W'(1) : exp_cnt;
        diff_s  = $signed({{(64-CNT_W){1'b0}}, meas}) - $signed({{(64-CNT_W){1'b0}}, exp_cnt});
        quo_s   = (diff_s * HPPM_S) / $signed({{(64-CNT_W){1'b0}}, den});
        if (quo_s > LIM_S) begin
            ofs_n = 8'(OFS_LIM);
        end else if (quo_s < -LIM_S) begin
            ofs_n = 8'd0 - 8'(OFS_LIM);
        end else begin
            ofs_n = quo_s[7:0];
        end
        ofs_mag = mag8(ofs_n);
        if (!present) begin
            st_n = ST_ABSENT;
        end else if (prio == 4'd0) begin
            st_n = ST_IDLE;
        end else if (ofs_mag > win) begin
            st_n = ST_OFFWIN;
        end else begin
            st_n = ST_GOOD;
        end

        if (gate_end) begin
            d.ecnt = '0;
            d.ofs  = ofs_n;
            d.st   = st_n;
        end else begin
            d.ecnt = meas;
        end

        if (edge_i) begin
            d.miss = '0;
        end else if (q.miss < MW'(MISS_CYC)) begin
            d.miss = q.miss + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ecnt <= '0;
            q.miss <= MW'(MISS_CYC);
            q.ofs  <= 8'hFF;
            q.st   <= ST_ABSENT;
        end else begin
            q <= d;
        end
    end

    a_r2_ofs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(ofs_o) <= 8'sd126) && ($signed(ofs_o) >= -8'sd126));

    a_r4_good_within_window: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end |=> ((st_o != ST_GOOD) || (mag8(ofs_o) <= $past(win))));

    a_r5_prio_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end && edge_i && prio == 4'd0) |=> (st_o == ST_IDLE));

    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> ($stable(ofs_o) && $stable(st_o)));

endmodule

// File: rtl/rfq_pick.sv
module rfq_pick
    import rfq_pkg::*;
#(
    parameter int NREF  = 6,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [2*NREF-1:0] st_flat,
    input  logic [8*NREF-1:0] ofs_flat,
    input  logic [4*NREF-1:0] prio_flat,
    input  logic              auto_sw,
    input  logic              min_off_sel,
    output logic              any_ok,
    output logic [SEL_W-1:0]  sel_idx
);
    typedef struct packed {
        logic             any;
        logic [SEL_W-1:0] sel;
    } pick_t;

    pick_t q, d;

    logic             use_ofs;
    logic             found;
    logic [SEL_W-1:0] best_i;
    logic [3:0]       best_p;
    logic [7:0]       best_m;
    logic [7:0]       cur_m;
    logic             better;

    assign any_ok  = q.any;
    assign sel_idx = q.sel;
    assign use_ofs = auto_sw && min_off_sel;

    always_comb begin
        d      = q;
        found  = 1'b0;
        best_i = '0;
        best_p = '0;
        best_m = '0;
        cur_m  = '0;
        better = 1'b0;
        for (int i = 0; i < NREF; i++) begin
            cur_m = mag8(ofs_flat[8*i +: 8]);
            if (st_flat[2*i +: 2] == ST_GOOD) begin
                better = use_ofs ? (cur_m < best_m) : (prio_flat[4*i +: 4] > best_p);
                if (!found || better) begin
                    found  = 1'b1;
                    best_i = SEL_W'(i);
                    best_p = prio_flat[4*i +: 4];
                    best_m = cur_m;
                end
            end
        end
        if (upd) begin
            d.any = found;
            d.sel = best_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r9_sel_is_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (!any_ok || (st_flat[2*sel_idx +: 2] == ST_GOOD)));

    a_r9_none_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !found) |=> (!any_ok && sel_idx == '0));

    a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(any_ok) && $stable(sel_idx)));

endmodule

// File: rtl/ref_qual_top.sv
module ref_qual_top #(
    parameter int NREF     = 6,
    parameter int CNT_W    = 24,
    parameter int GATE_CYC = 1000000,
    parameter int MISS_CYC = 1000,
    parameter int HPPM     = 2000000,
    localparam int SEL_W   = $clog2(NREF)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREF-1:0]       ref_edge,
    input  logic [NREF*CNT_W-1:0] exp_cnt,
    input  logic [7:0]            acc_win,
    input  logic [4*NREF-1:0]     prio_cfg,
    input  logic                  auto_sw,
    input  logic                  min_off_sel,
    output logic [8*NREF-1:0]     ofs_out,
    output logic [2*NREF-1:0]     stat_out,
    output logic                  any_ok,
    output logic [SEL_W-1:0]      sel_idx
);
    logic gate_end;
    logic upd;

    rfq_gate #(.GATE_CYC(GATE_CYC)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_end (gate_end),
        .upd      (upd)
    );

    for (genvar g = 0; g < NREF; g++) begin : g_chan
        rfq_chan #(
            .CNT_W    (CNT_W),
            .MISS_CYC (MISS_CYC),
            .HPPM     (HPPM)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_i   (ref_edge[g]),
            .gate_end (gate_end),
            .exp_cnt  (exp_cnt[CNT_W*g +: CNT_W]),
            .win      (acc_win),
            .prio     (prio_cfg[4*g +: 4]),
            .ofs_o    (ofs_out[8*g +: 8]),
            .st_o     (stat_out[2*g +: 2])
        );
    end

    rfq_pick #(.NREF(NREF), .SEL_W(SEL_W)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd         (upd),
        .st_flat     (stat_out),
        .ofs_flat    (ofs_out),
        .prio_flat   (prio_cfg),
        .auto_sw     (auto_sw),
        .min_off_sel (min_off_sel),
        .any_ok      (any_ok),
        .sel_idx     (sel_idx)
    );

endmodule

// File: tb/tb_ref_qual_top.sv
module tb_ref_qual_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREF  = 6;
    localparam int CNT_W = 12;
    localparam int GATE  = 200;
    localparam int MISS  = 20;
    localparam int HP    = 200;
    localparam int WAITC = 2 * GATE + 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NREF-1:0]       ref_edge = '0;
    logic [NREF*CNT_W-1:0] exp_cnt = '0;
    logic [7:0]            acc_win = 8'h1A;
    logic [4*NREF-1:0]     prio_cfg = 24'h345678;
    logic                  auto_sw = 1'b1;
    logic                  min_off_sel = 1'b0;
    logic [8*NREF-1:0]     ofs_out;
    logic [2*NREF-1:0]     stat_out;
    logic                  any_ok;
    logic [2:0]            sel_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int per [NREF];
    int cyc = 0;

    // behavioural model state
    int m_g = 0, m_pend = 0, m_any = 0, m_sel = 0;
    int m_cnt [NREF], m_miss [NREF], m_ofs [NREF], m_st [NREF];

    ref_qual_top #(.NREF(NREF), .CNT_W(CNT_W), .GATE_CYC(GATE), .MISS_CYC(MISS), .HPPM(HP)) dut (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .exp_cnt(exp_cnt),
        .acc_win(acc_win), .prio_cfg(prio_cfg), .auto_sw(auto_sw), .min_off_sel(min_off_sel),
        .ofs_out(ofs_out), .stat_out(stat_out), .any_ok(any_ok), .sel_idx(sel_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int iabs(input int v);
        return v < 0 ? -v : v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic set_exp(input int e0, input int e1, input int e2, input int e3, input int e4, input int e5);
        int e [NREF];
        e = '{e0, e1, e2, e3, e4, e5};
        for (int i = 0; i < NREF; i++) exp_cnt[CNT_W*i +: CNT_W] = CNT_W'(e[i]);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // edge stimulus, driven away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < NREF; i++)
            ref_edge[i] <= (per[i] != 0) && ((cyc % per[i]) == 0);
    end

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_g = 0; m_pend = 0; m_any = 0; m_sel = 0;
            for (int i = 0; i < NREF; i++) begin
                m_cnt[i] = 0; m_miss[i] = MISS; m_ofs[i] = -1; m_st[i] = 0;
            end
        end else begin
            if (m_pend != 0) begin
                int bp, bm;
                bit byofs;
                byofs = auto_sw && min_off_sel;
                m_any = 0; m_sel = 0; bp = 0; bm = 0;
                for (int i = 0; i < NREF; i++) begin
                    if (m_st[i] == 3) begin
                        int p, mg;
                        p = int'(prio_cfg[4*i +: 4]);
                        mg = iabs(m_ofs[i]);
                        if (m_any == 0 || (byofs ? (mg < bm) : (p > bp))) begin
                            m_any = 1; m_sel = i; bp = p; bm = mg;
                        end
                    end
                end
            end
            for (int i = 0; i < NREF; i++) begin
                int e;
                bit pres;
                e = int'(ref_edge[i]);
                pres = (e != 0) || (m_miss[i] < MISS);
                if (m_g == GATE - 1) begin
                    longint meas, ex, den, q;
                    meas = m_cnt[i] + e;
                    ex = longint'(exp_cnt[CNT_W*i +: CNT_W]);
                    den = (ex == 0) ? 1 : ex;
                    q = ((meas - ex) * HP) / den;
                    if (q > 126) q = 126;
                    if (q < -126) q = -126;
                    m_ofs[i] = int'(q);
                    if (!pres) m_st[i] = 0;
                    else if (prio_cfg[4*i +: 4] == 4'd0) m_st[i] = 2;
                    else if (iabs(m_ofs[i]) > int'(acc_win)) m_st[i] = 1;
                    else m_st[i] = 3;
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = m_cnt[i] + e;
                end
                if (e != 0) m_miss[i] = 0;
                else if (m_miss[i] < MISS) m_miss[i] = m_miss[i] + 1;
            end
            m_pend = (m_g == GATE - 1) ? 1 : 0;
            m_g = (m_g == GATE - 1) ? 0 : m_g + 1;
        end
    end

    // cycle-by-cycle comparison; any drift between updates also covers R10
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [8*NREF-1:0] eo;
            logic [2*NREF-1:0] es;
            for (int i = 0; i < NREF; i++) begin
                eo[8*i +: 8] = 8'(m_ofs[i]);
                es[2*i +: 2] = 2'(m_st[i]);
            end
            check("R1 offsets vs model", 64'(ofs_out), 64'(eo));
            check("R4 statuses vs model", 64'(stat_out), 64'(es));
            check("R7 selection vs model", {60'd0, any_ok, sel_idx}, {60'd0, 1'(m_any), 3'(m_sel)});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NREF; i++) per[i] = 4;
        set_exp(50, 50, 50, 50, 50, 50);
        repeat (5) @(negedge clk);
        check("R6 reset offsets", 64'(ofs_out), 64'(48'hFFFF_FFFF_FFFF));
        check("R6 reset statuses", 64'(stat_out), 64'd0);
        check("R6 reset any/sel", {60'd0, any_ok, sel_idx}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after release", 64'(ofs_out), 64'(48'hFFFF_FFFF_FFFF));

        // nominal: all qualified, priority 8 on ref 0 wins
        repeat (WAITC) @(negedge clk);
        check("R1 all offsets zero", 64'(ofs_out), 64'd0);
        check("R4 all qualified", 64'(stat_out), 64'hFFF);
        check("R7 highest priority", {60'd0, any_ok, sel_idx}, {60'd0, 1'b1, 3'd0});

        // mixed conditions
        per[0] = 0;
        set_exp(50, 47, 50, 20, 43, 53);
        prio_cfg = 24'h345078;
        repeat (WAITC) @(negedge clk);
        check("R2 negative saturation ref0", 64'(ofs_out[7:0]), 64'h82);
        check("R3 absent ref0", 64'(stat_out[1:0]), 64'd0);
        check("R1 positive truncation ref1", 64'(ofs_out[15:8]), 64'h0C);
        check("R5 priority zero ref2", 64'(stat_out[5:4]), 64'd2);
        check("R2 positive saturation ref3", 64'(ofs_out[31:24]), 64'h7E);
        check("R4 outside window ref3/ref4", 64'(stat_out[9:6]), 64'h5);
        check("R1 negative truncation ref5", 64'(ofs_out[47:40]), 64'hF5);
        check("R7 priority pick", {60'd0, any_ok, sel_idx}, {60'd0, 1'b1, 3'd1});
        min_off_sel = 1'b1;
        repeat (WAITC) @(negedge clk);
        check("R8 best offset pick", {60'd0, any_ok, sel_idx}, {60'd0, 1'b1, 3'd5});
        auto_sw = 1'b0;
        repeat (WAITC) @(negedge clk);
        check("R8 needs auto switching", {60'd0, any_ok, sel_idx}, {60'd0, 1'b1, 3'd1});

        // ties
        auto_sw = 1'b1; min_off_sel = 1'b0;
        per[0] = 4;
        set_exp(50, 50, 50, 50, 50, 50);
        prio_cfg = 24'h111111;
        repeat (WAITC) @(negedge clk);
        check("R7 priority tie to lower index", {60'd0, any_ok, sel_idx}, {60'd0, 1'b1, 3'd0});
        min_off_sel = 1'b1;
        per[0] = 0;
        repeat (WAITC) @(negedge clk);
        check("R8 offset tie to lower index", {60'd0, any_ok, sel_idx}, {60'd0, 1'b1, 3'd1});

        // nothing qualifies
        per[0] = 4;
        acc_win = 8'h00;
        set_exp(49, 49, 49, 49, 49, 49);
        repeat (WAITC) @(negedge clk);
        check("R4 all outside zero window", 64'(stat_out), 64'h555);
        check("R9 none qualified", {60'd0, any_ok, sel_idx}, 64'd0);

        // sparse reference near the timeout, compared against the model only (R3)
        acc_win = 8'h1A;
        set_exp(50, 50, 50, 50, 50, 8);
        per[5] = 25;
        repeat (3 * GATE) @(negedge clk);

        done = 1;
        finish_run();
    end

endmodule